// File: doc/BRIEF.md
# SHA-256 Block Compression Core

This core applies the SHA-256 compression function to a single 512-bit block that has already been padded. An outer controller presents sixteen 32-bit message words and the eight-word chaining hash, then pulses `start`. The core returns the updated eight-word hash. The controller feeds that hash back as `hash_in` for the next block of the same message. Padding, splitting a message into blocks and joining the final words into a digest stay outside the core.

The core does not compute the whole message schedule in advance. It keeps a sliding window of the sixteen newest schedule words and forms each new word in the same cycle as the round that uses it. The sum of `h`, the round constant and the schedule word is common to both round results. The core registers that sum one round ahead, which takes two adders off the round path.

The controller has three states:
- `IDLE`: waits for `start`. The transition `LOAD` (IDLE→ROUND) captures the inputs, loads the working variables and seeds the shared sum.
- `ROUND`: runs 64 round cycles. The transition `LAST_ROUND` (ROUND→FINAL) is taken when the round counter reaches 63.
- `FINAL`: adds the working variables to the captured hash and pulses `done`. The transition `FINISH` (FINAL→IDLE) follows.

Top module: `sha256_compress`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `hash_out` is all zero.
- R2: `done` rises exactly 66 clock cycles after the rising edge at which `start` is sampled in the idle state. That edge counts as cycle 1, and `done` is visible after the 66th edge.
- R3: `done` is high for exactly one cycle. `busy` is high from the cycle after the start edge until `done` rises, and `busy` is low while `done` is high.
- R4: Word order on every port is index 0 first, and index 0 is the most significant word of the packed vector. With this order, a block that holds the padded message "abc" and starts from the standard initial hash yields ba7816bf 8f01cfea 414140de 5dae2223 b00361a3 96177a9c b410ff61 f20015ad.
- R5: Chaining works. The 56-byte message "abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq" gives 85e655d6 417a1795 3363376a 624cde5c 76e09589 cac5f811 cc4b32c1 f20e533a after its first block. Feeding that result back as `hash_in` with the second block gives 248d6a61 d20638b8 e5c02693 0c3e6039 a33ce459 64ff2167 f6ecedd4 19db06c1.
- R6: A `start` pulse while `busy` is high is ignored. The running block still finishes on the original schedule with the original result, and no second block follows.
- R7: `hash_out` changes only at the edge at which `done` rises. It holds its value between blocks.
- R8: `msg_in` and `hash_in` are sampled only at the start edge. Changing them afterwards does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block; sampled only in idle |
| msg_in | input | 512 | Sixteen message words, word 0 in the top bits |
| hash_in | input | 256 | Eight chaining-hash words, word 0 in the top bits |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle pulse when `hash_out` is updated |
| hash_out | output | 256 | Updated hash, word 0 in the top bits |

## Verification
The bench builds the core with its package defaults: 32-bit words, a 16-word window and 64 rounds. These are the only values for which published SHA-256 results exist. With them, the bench can compare against the known digests for "abc" and for the two-block message, including the intermediate hash after the first block. The bench also counts the exact 66-cycle latency. It pokes `start` and the data inputs during a running block, which checks that the inputs are captured at the load edge and that extra start pulses are ignored.

// File: rtl/sha256_pkg.sv
package sha256_pkg;
    localparam int WORD_W   = 32;
    localparam int N_MSG    = 16;
    localparam int N_STATE  = 8;
    localparam int N_ROUNDS = 64;
    localparam int RND_W    = $clog2(N_ROUNDS);

    typedef logic [WORD_W-1:0]             word_t;
    typedef logic [0:N_STATE-1][WORD_W-1:0] state_t;
    typedef logic [0:N_MSG-1][WORD_W-1:0]   block_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ROUND = 2'd1,
        ST_FINAL = 2'd2
    } ctl_state_t;

    localparam word_t K_TAB [0:N_ROUNDS-1] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
        32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
        32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
        32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
        32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
        32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
        32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
        32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
        32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_sig0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_sig1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t small_sig0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t small_sig1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction
endpackage

// File: rtl/sha256_sched.sv
module sha256_sched
    import sha256_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  logic   shift,
    input  block_t load_words,
    output word_t  w_cur,
    output word_t  w_nxt
);
    block_t win;
    word_t  w_new;

    // word t+16 from the window holding words t .. t+15
    assign w_new = small_sig1(win[N_MSG-2]) + win[N_MSG-7]
                 + small_sig0(win[1]) + win[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win <= '0;
        end else if (load) begin
            win <= load_words;
        end else if (shift) begin
            for (int i = 0; i < N_MSG - 1; i++) begin
                win[i] <= win[i+1];
            end
            win[N_MSG-1] <= w_new;
        end
    end

    assign w_cur = win[0];
    assign w_nxt = win[1];

    // R4: the window advances by one word per round
    assert_win_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (win[N_MSG-2] == $past(win[N_MSG-1])));
endmodule

// File: rtl/sha256_round.sv
module sha256_round
    import sha256_pkg::*;
(
    input  state_t v,
    input  word_t  alpha,
    input  word_t  k_nxt,
    input  word_t  w_nxt,
    output state_t v_next,
    output word_t  alpha_next
);
    word_t t1, t2, ch, maj;

    always_comb begin
        ch  = (v[4] & v[5]) ^ (~v[4] & v[6]);
        maj = (v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]);
        t1  = alpha + big_sig1(v[4]) + ch;
        t2  = big_sig0(v[0]) + maj;
        v_next[0] = t1 + t2;
        v_next[1] = v[0];
        v_next[2] = v[1];
        v_next[3] = v[2];
        v_next[4] = v[3] + t1;
        v_next[5] = v[4];
        v_next[6] = v[5];
        v_next[7] = v[6];
        // g moves into h, so it seeds the next round's shared sum
        alpha_next = v[6] + k_nxt + w_nxt;
    end
endmodule

// File: rtl/sha256_compress.sv
module sha256_compress
    import sha256_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  block_t msg_in,
    input  state_t hash_in,
    output logic   busy,
    output logic   done,
    output state_t hash_out
);
    ctl_state_t state, state_nx;
    logic [RND_W-1:0] rnd, rnd_nx;
    state_t v, v_next, hash_q;
    word_t  alpha, alpha_next, w_cur, w_nxt;
    logic   do_load, do_round;
    logic [6:0] lat_cnt;

    assign do_load  = (state == ST_IDLE) && start;
    assign do_round = (state == ST_ROUND);
    assign rnd_nx   = rnd + 1'b1;

    sha256_sched u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (do_load),
        .shift      (do_round),
        .load_words (msg_in),
        .w_cur      (w_cur),
        .w_nxt      (w_nxt)
    );

    sha256_round u_round (
        .v          (v),
        .alpha      (alpha),
        .k_nxt      (K_TAB[rnd_nx]),
        .w_nxt      (w_nxt),
        .v_next     (v_next),
        .alpha_next (alpha_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_ROUND;
            ST_ROUND: if (rnd == RND_W'(N_ROUNDS - 1)) state_nx = ST_FINAL;
            ST_FINAL: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            hash_out <= '0;
            hash_q   <= '0;
            v        <= '0;
            alpha    <= '0;
            rnd      <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        busy   <= 1'b1;
                        hash_q <= hash_in;
                        v      <= hash_in;
                        alpha  <= hash_in[N_STATE-1] + K_TAB[0] + msg_in[0];
                        rnd    <= '0;
                    end
                end
                ST_ROUND: begin
                    v     <= v_next;
                    alpha <= alpha_next;
                    rnd   <= rnd_nx;
                end
                ST_FINAL: begin
                    for (int i = 0; i < N_STATE; i++) begin
                        hash_out[i] <= hash_q[i] + v[i];
                    end
                    done <= 1'b1;
                    busy <= 1'b0;
                end
                default: busy <= 1'b0;
            endcase
        end
    end

    // independent latency counter used only by the checks below
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lat_cnt <= '0;
        else if (do_load) lat_cnt <= '0;
        else if (busy)    lat_cnt <= lat_cnt + 1'b1;
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == 7'd65));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && state != ST_FINAL) |=> busy);

    assert_out_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(hash_out));
endmodule

// File: tb/sha256_compress_test.sv
module sha256_compress_test;
    import sha256_pkg::*;

    logic   clk = 1'b0;
    logic   rst_n = 1'b0;
    logic   start = 1'b0;
    block_t msg_in = '0;
    state_t hash_in = '0;
    logic   busy, done;
    state_t hash_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sha256_compress uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .msg_in   (msg_in),
        .hash_in  (hash_in),
        .busy     (busy),
        .done     (done),
        .hash_out (hash_out)
    );

    typedef struct packed {
        block_t m;
        state_t h;
        state_t e;
    } vec_t;

    localparam state_t IV = 256'h6a09e667_bb67ae85_3c6ef372_a54ff53a_510e527f_9b05688c_1f83d9ab_5be0cd19;
    localparam state_t MID2 = 256'h85e655d6_417a1795_3363376a_624cde5c_76e09589_cac5f811_cc4b32c1_f20e533a;
    localparam state_t FIN2 = 256'h248d6a61_d20638b8_e5c02693_0c3e6039_a33ce459_64ff2167_f6ecedd4_19db06c1;
    localparam state_t ABC_D = 256'hba7816bf_8f01cfea_414140de_5dae2223_b00361a3_96177a9c_b410ff61_f20015ad;
    localparam block_t ABC_M = {32'h61626380, {14{32'h0}}, 32'h00000018};
    localparam block_t TWO_M1 = {32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
                                 32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
                                 32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
                                 32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
    localparam block_t TWO_M2 = {{15{32'h0}}, 32'h000001c0};

    localparam vec_t VECS [0:2] = '{
        '{m: ABC_M,  h: IV,   e: ABC_D},
        '{m: TWO_M1, h: IV,   e: MID2},
        '{m: TWO_M2, h: MID2, e: FIN2}
    };

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // runs a block; poke_at>0 pulses start with other data at that cycle (R6)
    task automatic run_block(input block_t m, input state_t h, input int poke_at,
                             output state_t res, output int cycles);
        int n;
        msg_in  = m;
        hash_in = h;
        start   = 1'b1;
        @(posedge clk);
        #1;
        start   = 1'b0;
        msg_in  = ~m;            // R8: inputs change after the start edge
        hash_in = ~h;
        n = 1;
        check(busy === 1'b1, "R3 busy after start", 256'(busy), 256'd1);
        while (done !== 1'b1 && n < 200) begin
            if (n == poke_at) start = 1'b1;
            @(posedge clk);
            #1;
            start = 1'b0;
            n++;
        end
        cycles = n;
        res = hash_out;
        check(busy === 1'b0, "R3 busy low with done", 256'(busy), 256'd0);
        @(posedge clk);
        #1;
        check(done === 1'b0, "R3 done single pulse", 256'(done), 256'd0);
        check(busy === 1'b0, "R6 no second block", 256'(busy), 256'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        state_t res, keep;
        int cyc;

        #5;
        check(busy === 1'b0, "R1 busy reset", 256'(busy), 256'd0);
        check(done === 1'b0, "R1 done reset", 256'(done), 256'd0);
        check(hash_out === '0, "R1 hash_out reset", hash_out, 256'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        for (int i = 0; i < 3; i++) begin
            run_block(VECS[i].m, VECS[i].h, 0, res, cyc);
            check(cyc == 66, "R2 latency", 256'(cyc), 256'd66);
            check(res === VECS[i].e, (i == 0) ? "R4 abc digest" : "R5 chained block",
                  res, VECS[i].e);
        end

        // R5: chain the real output of block 1 into block 2
        run_block(TWO_M1, IV, 0, res, cyc);
        check(res === MID2, "R5 intermediate", res, MID2);
        run_block(TWO_M2, res, 0, res, cyc);
        check(res === FIN2, "R5 final digest", res, FIN2);

        // R6: start pulses mid-run are ignored
        run_block(ABC_M, IV, 10, res, cyc);
        check(cyc == 66, "R6 latency with stray start", 256'(cyc), 256'd66);
        check(res === ABC_D, "R6 result with stray start", res, ABC_D);
        run_block(ABC_M, IV, 65, res, cyc);
        check(res === ABC_D, "R6 start on last round", res, ABC_D);

        // R7: output holds while idle with changing inputs
        keep = hash_out;
        for (int j = 0; j < 5; j++) begin
            msg_in  = {16{32'(j * 32'h01010101)}};
            hash_in = {8{32'(j)}};
            @(posedge clk);
            #1;
        end
        check(hash_out === keep, "R7 hash_out holds", hash_out, keep);
        check(done === 1'b0 && busy === 1'b0, "R7 idle stays idle",
              256'({done, busy}), 256'd0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule